// File: doc/BRIEF.md
# CAM Match and Status Unit

A small content-addressable memory whose entries each hold a 64-bit word and two validity bits, Skip and Empty. A write strobe stores a word and its validity bits at an entry address. A compare strobe presents a comparand. Every entry that holds data and is not skipped is checked against it, and a loadable bit mask can exclude chosen bit positions from the check. A read strobe returns a stored word and records that entry's validity bits.

All the flags are active low. The unit reports whether any entry matched, whether more than one matched, and whether the memory has no empty entry left. It also gives the index of the lowest-numbered matching entry. These results are packed into a fixed 32-bit status word together with a page address supplied from outside. The surrounding logic uses this word to place a device within a larger system.

Top module: `cam_match_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears itself. From the following cycle every entry is empty, the mask is zero, and the read validity field reads 11. `match_n`, `multi_n` and `full_n` read 1, and the match-address field reads all ones.
- R2: When `wr_en` is high at an edge, `wr_data`, `wr_skip` and `wr_empty` are stored in entry `wr_addr`.
- R3: An entry matches when its Empty bit is 0 and its Skip bit is 0 and `(word ^ cmp_data) & ~mask` is zero. After an edge with `cmp_en` high, `match_n` is 0 if any entry matched and 1 otherwise. It then holds until the next compare or reset.
- R4: After a compare with at least one match, the match-address field `status[ADDR_W:1]` holds the lowest index among the matching entries.
- R5: After a compare, `multi_n` is 0 when two or more entries matched and 1 otherwise.
- R6: After a compare with no match, the match-address field is all ones.
- R7: `full_n` is 0 exactly when no entry has Empty = 1. It follows the stored bits from the cycle after the write.
- R8: After an edge with `rd_en` high, `rd_data` holds the word of entry `rd_addr`, and `status[29]`/`status[28]` hold that entry's Skip/Empty bits.
- R9: After an edge with `mask_ld` high, the mask holds `mask_data`. A mask bit of 1 makes that bit position a don't-care in later compares.
- R10: The layout of `status` is as follows. Bit 31 is `full_n`, bit 30 is `multi_n`, and bits 29 and 28 are the read Skip and Empty bits. Bits 27 down to ADDR_W+1 carry `page_addr`. Bits ADDR_W down to 1 carry the match address, and bit 0 is `match_n`.
- R11: A compare in the same cycle as a write is evaluated against the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Entry written |
| wr_data | input | 64 | Word written |
| wr_skip | input | 1 | Skip bit written |
| wr_empty | input | 1 | Empty bit written |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Entry read |
| cmp_en | input | 1 | Compare strobe |
| cmp_data | input | 64 | Comparand |
| mask_ld | input | 1 | Mask load strobe |
| mask_data | input | 64 | New mask, 1 = ignore bit |
| page_addr | input | 27-ADDR_W | Page address placed in the status word |
| rd_data | output | 64 | Word of the last read entry |
| match_n | output | 1 | Match flag, active low |
| multi_n | output | 1 | Multiple-match flag, active low |
| full_n | output | 1 | Full flag, active low |
| status | output | 32 | Packed status word |

## Verification
The hardest state to reach is one where priority, masking and validity all act on the same compare. In that state a lower-numbered entry would match only because of masked bits, or it is skipped or empty, while a higher entry truly matches. The stimulus first loads look-alike words into several entries, differing only in masked bits, and sets Skip or Empty on some of the low ones. It then issues compares that depend on each of those exclusions. The bench also fills every entry to drive `full_n` low, and it lands a write on the entry being compared in the same cycle.

// File: rtl/cam_match_status.sv
module cam_match_status #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              wr_skip,
  input  logic              wr_empty,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cmp_en,
  input  logic [WIDTH-1:0]  cmp_data,
  input  logic              mask_ld,
  input  logic [WIDTH-1:0]  mask_data,
  input  logic [26-ADDR_W:0] page_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              match_n,
  output logic              multi_n,
  output logic              full_n,
  output logic [31:0]       status
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0]  word  [DEPTH];
  logic [DEPTH-1:0]  skip, empty, hit;
  logic [WIDTH-1:0]  mask;
  logic [ADDR_W-1:0] hit_addr, m_addr;
  logic              rd_skip, rd_empty;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = !empty[i] && !skip[i] && (((word[i] ^ cmp_data) & ~mask) == '0);
    hit_addr = '1;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i]) hit_addr = ADDR_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip     <= '0;
      empty    <= '1;
      mask     <= '0;
      rd_skip  <= 1'b1;
      rd_empty <= 1'b1;
      rd_data  <= '0;
      match_n  <= 1'b1;
      multi_n  <= 1'b1;
      m_addr   <= '1;
    end else begin
      if (wr_en) begin
        word[wr_addr]  <= wr_data;
        skip[wr_addr]  <= wr_skip;
        empty[wr_addr] <= wr_empty;
      end
      if (mask_ld) mask <= mask_data;
      if (rd_en) begin
        rd_data  <= word[rd_addr];
        rd_skip  <= skip[rd_addr];
        rd_empty <= empty[rd_addr];
      end
      if (cmp_en) begin
        match_n <= (hit == '0);
        multi_n <= !($countones(hit) > 1);
        m_addr  <= hit_addr;
      end
    end
  end

  assign full_n = |empty;
  assign status = {full_n, multi_n, rd_skip, rd_empty, page_addr, m_addr, match_n};
endmodule

module cam_match_status_chk #(
  parameter int ADDR_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_en,
  input logic        match_n,
  input logic        multi_n,
  input logic        full_n,
  input logic [31:0] status
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (status[29:28] == 2'b11 && match_n && multi_n && full_n &&
                status[ADDR_W:1] == '1));

  // R5
  multi_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_n |-> !match_n);

  // R6
  nomatch_addr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_n |-> status[ADDR_W:1] == '1);

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(match_n) && $stable(multi_n) && $stable(status[ADDR_W:1])));

  // R10
  layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[31] == full_n && status[30] == multi_n && status[0] == match_n);
endmodule

bind cam_match_status cam_match_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .match_n(match_n),
  .multi_n(multi_n), .full_n(full_n), .status(status));

// File: tb/tb_cam_match_status.sv
module tb_cam_match_status;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_skip = 0, wr_empty = 0, rd_en = 0, cmp_en = 0, mask_ld = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0, cmp_data = '0, mask_data = '0;
  logic [26-AW:0] page_addr = 23'h5A3C1;
  logic [63:0] rd_data;
  logic match_n, multi_n, full_n;
  logic [31:0] status;

  int checks = 0, fails = 0;

  logic [63:0] m_word [N];
  bit m_skip [N];
  bit m_empty [N];
  logic [63:0] m_mask = '0, m_rd = '0;
  bit m_rs = 1, m_re = 1, m_match_n = 1, m_multi_n = 1;
  logic [AW-1:0] m_addr = '1;

  cam_match_status #(.ADDR_W(AW)) dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int cnt = 0;
    int first = -1;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_skip[i] = 0; m_empty[i] = 1; end
      m_mask = '0; m_rs = 1; m_re = 1; m_rd = '0;
      m_match_n = 1; m_multi_n = 1; m_addr = '1;
      return;
    end
    if (cmp_en) begin
      for (int i = 0; i < N; i++)
        if (!m_empty[i] && !m_skip[i] && (((m_word[i] ^ cmp_data) & ~m_mask) == 0)) begin
          cnt++;
          if (first < 0) first = i;
        end
      m_match_n = (cnt == 0);
      m_multi_n = (cnt < 2);
      m_addr = (cnt == 0) ? '1 : AW'(first);
    end
    if (rd_en) begin
      m_rd = m_word[rd_addr]; m_rs = m_skip[rd_addr]; m_re = m_empty[rd_addr];
    end
    if (wr_en) begin
      m_word[wr_addr] = wr_data; m_skip[wr_addr] = wr_skip; m_empty[wr_addr] = wr_empty;
    end
    if (mask_ld) m_mask = mask_data;
  endtask

  task automatic step();
    bit full;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    full = 1;
    for (int i = 0; i < N; i++) if (m_empty[i]) full = 0;
    chk("R3 match_n", match_n, m_match_n);
    chk("R5 multi_n", multi_n, m_multi_n);
    chk("R7 full_n", full_n, !full);
    chk("R4/R6 match address", status[AW:1], m_addr);
    chk("R8 rd_data", rd_data, m_rd);
    chk("R10 status word", status, {!full, m_multi_n, m_rs, m_re, page_addr, m_addr, m_match_n});
    wr_en = 0; rd_en = 0; cmp_en = 0; mask_ld = 0;
  endtask

  task automatic wr(int a, logic [63:0] d, bit s, bit e);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_skip = s; wr_empty = e; step();
  endtask
  task automatic cmp(logic [63:0] d);  // R3
    cmp_en = 1; cmp_data = d; step();
  endtask
  task automatic rd(int a);  // R8
    rd_en = 1; rd_addr = AW'(a); step();
  endtask

  initial begin
    step(); step();                       // R1 reset state
    rst_n = 1;
    step();
    cmp(64'h0);                           // R6 empty memory: no match
    wr(3, 64'hDEAD_BEEF_0000_1111, 0, 0); // R2
    wr(9, 64'hDEAD_BEEF_0000_1111, 0, 0);
    wr(5, 64'hDEAD_BEEF_0000_1100, 0, 0);
    cmp(64'hDEAD_BEEF_0000_1111);         // R4 R5 lowest of two
    cmp(64'hDEAD_BEEF_0000_1100);         // R3 single
    cmp(64'h1234);                        // R6 no match
    mask_ld = 1; mask_data = 64'hFF; step(); // R9
    cmp(64'hDEAD_BEEF_0000_11AA);         // R9 masked: 3,5,9 match
    wr(3, 64'hDEAD_BEEF_0000_1111, 1, 0); // skip entry 3
    cmp(64'hDEAD_BEEF_0000_11AA);         // R3 skip excluded -> 5
    wr(5, 64'hDEAD_BEEF_0000_1100, 0, 1); // empty entry 5
    cmp(64'hDEAD_BEEF_0000_1111);         // only 9
    rd(3); rd(5); rd(9); rd(0);           // R8
    wr_en = 1; wr_addr = 4'd9; wr_data = 64'h0; wr_skip = 0; wr_empty = 0;
    cmp_en = 1; cmp_data = 64'hDEAD_BEEF_0000_1111; step(); // R11
    cmp(64'hDEAD_BEEF_0000_1111);
    for (int i = 0; i < N; i++) wr(i, 64'hA5A5_0000_0000_0000 | 64'(i), 0, 0); // R7 fill
    cmp(64'hA5A5_0000_0000_000F);
    cmp(64'hA5A5_0000_0000_0000);         // masked: all match, lowest 0
    mask_ld = 1; mask_data = 64'h0; step();
    cmp(64'hA5A5_0000_0000_000F);         // R4 top index 15
    wr(7, 64'h0, 0, 1);                   // R7 not full
    step();
    rst_n = 0; step();                    // R1 mid-run reset
    rst_n = 1; step();
    cmp(64'hA5A5_0000_0000_0003);         // entries cleared
    rd(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule